// File: doc/BRIEF.md
# Address-Generation Shift-and-Add Execution Unit

This unit decodes and executes the bit-manipulation instructions that speed up address arithmetic. Each takes one 32-bit instruction word and two source register values. The unit matches the word against eight encodings and computes the destination value. It returns the result one clock later, together with the destination register index, an illegal-instruction flag and a write enable for the register file. Three of the forms add a scaled base to an index. Four work on an unsigned 32-bit word held in a 64-bit register. The last one shifts such a word by an immediate amount.

The `XLEN` parameter selects a 32-bit or 64-bit machine. On a 32-bit machine the unsigned-word forms do not exist and are reported as illegal. The whole group can be switched off by three capability inputs: one for the dedicated address-generation capability, one for the broader bit-manipulation capability, and one for that capability's runtime enable bit. A word the unit does not support returns a zero result with the illegal flag raised. The surrounding pipeline can then raise an exception or pass the word to another unit.

Top module: `agu_bitops_unit`

## Requirements
- R1: With opcode bits[6:0]=0110011, bits[31:25]=0010000 and bits[14:12] equal to 010, 100 or 110, the result is rs2 + (rs1 << N), where N is 1, 2 or 3 in that order. These forms are legal for both XLEN values.
- R2: With opcode 0111011, bits[31:25]=0000100 and bits[14:12]=000, the result is rs2 plus the low 32 bits of rs1, zero-extended.
- R3: With opcode 0111011, bits[31:25]=0010000 and bits[14:12] equal to 010, 100 or 110, the result is rs2 + (zero-extended rs1[31:0] << N), where N is 1, 2 or 3.
- R4: With opcode 0011011, bits[31:26]=000010 and bits[14:12]=001, the result is the zero-extended rs1[31:0] shifted left by the amount in bits[25:20], which ranges from 0 to 63. No addition takes place.
- R5: When XLEN is 32, every encoding under R2, R3 and R4 is reported as illegal.
- R6: The group is enabled when cap_addr_grp is 1, or when cap_bitmanip and bitmanip_on are both 1. While the group is disabled, all eight encodings are reported as illegal.
- R7: A word that matches no enabled and legal encoding raises rsp_illegal. In that case rsp_result is zero and rsp_wr_en is low.
- R8: A request is accepted on a clock edge where req_valid and req_ready are both high. On the next edge rsp_valid is high for exactly one cycle, and rsp_rd carries bits[11:7] of the accepted word.
- R9: While rst_n is low, and in the cycle after it, rsp_valid, rsp_wr_en and req_ready are low. From then on req_ready stays high.
- R10: An edge with no accepted request leaves rsp_valid low in the following cycle.
- R11: All arithmetic wraps modulo 2^XLEN. Bits shifted or carried past the top are lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_insn | input | 32 | Instruction word |
| req_rs1_val | input | XLEN | First source operand |
| req_rs2_val | input | XLEN | Second source operand |
| cap_addr_grp | input | 1 | Address-generation capability present |
| cap_bitmanip | input | 1 | Broader bit-manipulation capability present |
| bitmanip_on | input | 1 | Runtime enable of the broader capability |
| rsp_valid | output | 1 | Response present, one cycle per accepted request |
| rsp_result | output | XLEN | Destination value, zero when illegal |
| rsp_rd | output | 5 | Destination register index |
| rsp_illegal | output | 1 | Word is not a legal, enabled instruction of the group |
| rsp_wr_en | output | 1 | Register file write enable |

## Verification
The assertions assume that the capability inputs and the instruction word are stable while req_valid is high. They also assume that nothing depends on a response in a cycle where no request was accepted. The bench drives every request for exactly one cycle at the falling edge, then leaves an idle cycle, so both assumptions always hold. A 64-bit and a 32-bit instance receive the same words. This lets one sweep cover every encoding under all eight capability combinations, every single-bit corruption of each encoding, random words, and edge operands: an all-ones upper half, bit 31 set, and shift amounts of 32 and 63.

// File: rtl/agu_pkg.sv
// Package agu_pkg
// Holds the encodings the decoder matches and the decoded-operation record
// that passes from the decoder to the datapath and the response stage.
// Assumes standard 32-bit instruction fields (opcode [6:0], funct3 [14:12]).
package agu_pkg;

    localparam logic [6:0] OPC_REG      = 7'b0110011;
    localparam logic [6:0] OPC_REG_W    = 7'b0111011;
    localparam logic [6:0] OPC_IMM_W    = 7'b0011011;
    localparam logic [6:0] F7_SCALE     = 7'b0010000;
    localparam logic [6:0] F7_WORD_ADD  = 7'b0000100;
    localparam logic [5:0] F6_WORD_SHL  = 6'b000010;
    localparam logic [2:0] F3_WORD_ADD  = 3'b000;
    localparam logic [2:0] F3_WORD_SHL  = 3'b001;

    typedef enum logic [1:0] {
        KIND_NONE     = 2'd0,
        KIND_SCALE    = 2'd1,
        KIND_SCALE_W  = 2'd2,
        KIND_SHL_W    = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [5:0]  shamt;
        logic        legal;
        logic [4:0]  rd;
    } dec_op_t;

endpackage

// File: rtl/agu_decode.sv
// Module agu_decode
// Purely combinational decoder. Matches the instruction word against the
// eight supported encodings, extracts shift amount and destination index,
// and applies the XLEN rule and the group enable to form the legal flag.
// Assumes XLEN is 32 or 64.
module agu_decode
    import agu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0] insn,
    input  logic        grp_on,
    output dec_op_t     dec
);
    localparam bit IS_WIDE = (XLEN == 64);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic       scale_f3;
    logic       word_form;
    logic       unused_fields;

    assign opc           = insn[6:0];
    assign f3            = insn[14:12];
    assign f7            = insn[31:25];
    assign scale_f3      = (f3[0] == 1'b0) && (f3 != 3'b000);
    assign unused_fields = ^insn[24:15];

    // Classify the word and pick its shift amount.
    always_comb begin
        dec.kind  = KIND_NONE;
        dec.shamt = '0;
        dec.rd    = insn[11:7];
        unique case (opc)
            OPC_REG: begin
                if (f7 == F7_SCALE && scale_f3) begin
                    dec.kind  = KIND_SCALE;
                    dec.shamt = {4'b0000, f3[2:1]};
                end
            end
            OPC_REG_W: begin
                if (f7 == F7_SCALE && scale_f3) begin
                    dec.kind  = KIND_SCALE_W;
                    dec.shamt = {4'b0000, f3[2:1]};
                end else if (f7 == F7_WORD_ADD && f3 == F3_WORD_ADD) begin
                    dec.kind  = KIND_SCALE_W;
                    dec.shamt = '0;
                end
            end
            OPC_IMM_W: begin
                if (insn[31:26] == F6_WORD_SHL && f3 == F3_WORD_SHL) begin
                    dec.kind  = KIND_SHL_W;
                    dec.shamt = insn[25:20];
                end
            end
            default: ;
        endcase
    end

    assign word_form = (dec.kind == KIND_SCALE_W) || (dec.kind == KIND_SHL_W);

    // Legal only when matched, enabled, and width-permitted.
    always_comb begin
        dec.legal = (dec.kind != KIND_NONE) && grp_on && (IS_WIDE || !word_form);
    end

endmodule

// File: rtl/agu_datapath.sv
// Module agu_datapath
// Computes the destination value for a decoded operation: optional
// zero-extension of the low word of the first operand, a left shift, and
// an optional add of the second operand. Result is zero when illegal.
// Assumes XLEN is 32 or 64; on 32-bit the low word is the whole operand.
module agu_datapath
    import agu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  dec_op_t          dec,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    output logic [XLEN-1:0]  result
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] word_zext;
    logic [XLEN-1:0] shift_in;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] addend;

    generate
        if (XLEN == 64) begin : g_wide
            assign word_zext = {{HALF{1'b0}}, src_a[HALF-1:0]};
        end else begin : g_narrow
            assign word_zext = src_a;
        end
    endgenerate

    // Select the shifter input by operation kind.
    always_comb begin
        shift_in = (dec.kind == KIND_SCALE) ? src_a : word_zext;
    end

    // Shift left; bits past the top are dropped.
    always_comb begin
        shifted = shift_in << dec.shamt;
    end

    // Only the shift-immediate form skips the add.
    always_comb begin
        addend = (dec.kind == KIND_SHL_W) ? '0 : src_b;
    end

    // Final sum, forced to zero for illegal words.
    always_comb begin
        result = dec.legal ? (shifted + addend) : '0;
    end

endmodule

// File: rtl/agu_rsp_stage.sv
// Module agu_rsp_stage
// One-cycle response register. Captures result, destination and legality
// on an accepted request and pulses the valid for a single cycle.
// Assumes synchronous active-low reset.
module agu_rsp_stage
    import agu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  dec_op_t          dec,
    input  logic [XLEN-1:0]  result_d,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_result,
    output logic [4:0]       rsp_rd,
    output logic             rsp_illegal,
    output logic             rsp_wr_en
);
    // Valid and write-enable pulse once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_wr_en <= 1'b0;
        end else begin
            rsp_valid <= fire;
            rsp_wr_en <= fire && dec.legal;
        end
    end

    // Payload is loaded on accept and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_result  <= '0;
            rsp_rd      <= '0;
            rsp_illegal <= 1'b0;
        end else if (fire) begin
            rsp_result  <= result_d;
            rsp_rd      <= dec.rd;
            rsp_illegal <= !dec.legal;
        end
    end

endmodule

// File: rtl/agu_bitops_unit.sv
// Module agu_bitops_unit (top)
// Decode-execute unit for the address-generation shift-and-add group.
// Accepts one request per cycle once out of reset and answers one cycle later.
// Assumes the register file, fetch and other instruction groups live elsewhere.
module agu_bitops_unit
    import agu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_insn,
    input  logic [XLEN-1:0]  req_rs1_val,
    input  logic [XLEN-1:0]  req_rs2_val,
    input  logic             cap_addr_grp,
    input  logic             cap_bitmanip,
    input  logic             bitmanip_on,
    output logic             rsp_valid,
    output logic [XLEN-1:0]  rsp_result,
    output logic [4:0]       rsp_rd,
    output logic             rsp_illegal,
    output logic             rsp_wr_en
);
    dec_op_t         dec;
    logic [XLEN-1:0] result_d;
    logic            grp_on;
    logic            ready_q;
    logic            fire;

    // Ready rises on the first edge after reset and stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    assign req_ready = ready_q;
    assign fire      = req_valid && ready_q;
    assign grp_on    = cap_addr_grp || (cap_bitmanip && bitmanip_on);

    agu_decode #(.XLEN(XLEN)) u_dec (
        .insn   (req_insn),
        .grp_on (grp_on),
        .dec    (dec)
    );

    agu_datapath #(.XLEN(XLEN)) u_dp (
        .dec    (dec),
        .src_a  (req_rs1_val),
        .src_b  (req_rs2_val),
        .result (result_d)
    );

    agu_rsp_stage #(.XLEN(XLEN)) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .dec         (dec),
        .result_d    (result_d),
        .rsp_valid   (rsp_valid),
        .rsp_result  (rsp_result),
        .rsp_rd      (rsp_rd),
        .rsp_illegal (rsp_illegal),
        .rsp_wr_en   (rsp_wr_en)
    );

endmodule

// File: rtl/agu_bitops_chk.sv
// Module agu_bitops_chk
// Port-level checker for agu_bitops_unit, attached by bind below.
// Assumes request inputs are sampled only on accepting edges.
module agu_bitops_chk #(
    parameter int XLEN = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_insn,
    input logic             cap_addr_grp,
    input logic             cap_bitmanip,
    input logic             bitmanip_on,
    input logic             rsp_valid,
    input logic [XLEN-1:0]  rsp_result,
    input logic [4:0]       rsp_rd,
    input logic             rsp_illegal,
    input logic             rsp_wr_en
);
    logic acc;
    logic off;
    logic word_opc;
    assign acc      = req_valid && req_ready;
    assign off      = !(cap_addr_grp || (cap_bitmanip && bitmanip_on));
    assign word_opc = (req_insn[6:0] == 7'b0111011) || (req_insn[6:0] == 7'b0011011);

    assert_wr_only_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr_en |-> (rsp_valid && !rsp_illegal));

    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_illegal) |-> (rsp_result == '0));

    assert_rsp_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    assert_rd_follows_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rsp_rd == $past(req_insn[11:7])));

    assert_idle_no_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    assert_disabled_illegal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && off) |=> rsp_illegal);

    generate
        if (XLEN == 32) begin : g_narrow_chk
            assert_word_forms_illegal_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (acc && word_opc) |=> rsp_illegal);
        end
    endgenerate

endmodule

bind agu_bitops_unit agu_bitops_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_insn     (req_insn),
    .cap_addr_grp (cap_addr_grp),
    .cap_bitmanip (cap_bitmanip),
    .bitmanip_on  (bitmanip_on),
    .rsp_valid    (rsp_valid),
    .rsp_result   (rsp_result),
    .rsp_rd       (rsp_rd),
    .rsp_illegal  (rsp_illegal),
    .rsp_wr_en    (rsp_wr_en)
);

// File: tb/agu_bitops_unit_tb_top.sv
`timescale 1ns/1ps
module agu_bitops_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_insn = '0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic        cap_a = 1'b1;
    logic        cap_b = 1'b0;
    logic        b_on  = 1'b0;

    logic        rdy64, vld64, ill64, wen64;
    logic [63:0] res64;
    logic [4:0]  rd64;
    logic        rdy32, vld32, ill32, wen32;
    logic [31:0] res32;
    logic [4:0]  rd32;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    agu_bitops_unit #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy64),
        .req_insn(req_insn), .req_rs1_val(rs1), .req_rs2_val(rs2),
        .cap_addr_grp(cap_a), .cap_bitmanip(cap_b), .bitmanip_on(b_on),
        .rsp_valid(vld64), .rsp_result(res64), .rsp_rd(rd64),
        .rsp_illegal(ill64), .rsp_wr_en(wen64)
    );

    agu_bitops_unit #(.XLEN(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy32),
        .req_insn(req_insn), .req_rs1_val(rs1[31:0]), .req_rs2_val(rs2[31:0]),
        .cap_addr_grp(cap_a), .cap_bitmanip(cap_b), .bitmanip_on(b_on),
        .rsp_valid(vld32), .rsp_result(res32), .rsp_rd(rd32),
        .rsp_illegal(ill32), .rsp_wr_en(wen32)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {illegal, result} from the requirement text.
    function automatic logic [64:0] model(input logic [31:0] w, input logic [63:0] a,
                                          input logic [63:0] b, input bit on, input bit wide);
        logic [6:0]  op = w[6:0];
        logic [2:0]  f3 = w[14:12];
        logic [6:0]  f7 = w[31:25];
        logic [63:0] lo = {32'h0, a[31:0]};
        logic [63:0] r = '0;
        bit          hit = 0;
        bit          wform = 0;
        int          n = f3 / 2;
        bit          nok = (f3 == 3'd2) || (f3 == 3'd4) || (f3 == 3'd6);
        if (op == 7'b0110011 && f7 == 7'b0010000 && nok) begin           // R1
            hit = 1; r = (a << n) + b;
        end else if (op == 7'b0111011 && f7 == 7'b0000100 && f3 == 3'd0) begin // R2
            hit = 1; wform = 1; r = lo + b;
        end else if (op == 7'b0111011 && f7 == 7'b0010000 && nok) begin  // R3
            hit = 1; wform = 1; r = (lo << n) + b;
        end else if (op == 7'b0011011 && w[31:26] == 6'b000010 && f3 == 3'd1) begin // R4
            hit = 1; wform = 1; r = lo << w[25:20];
        end
        if (!hit || !on || (wform && !wide)) return {1'b1, 64'h0};
        if (!wide) r = {32'h0, ((a[31:0] << n) + b[31:0])};
        return {1'b0, r};
    endfunction

    function automatic logic [31:0] enc(input int k, input logic [4:0] rd,
                                        input logic [4:0] s1, input logic [4:0] s2,
                                        input logic [5:0] sh);
        logic [2:0] f3n = 3'((k % 3 + 1) * 2);
        case (k)
            0, 1, 2: return {7'b0010000, s2, s1, f3n, rd, 7'b0110011};
            3:       return {7'b0000100, s2, s1, 3'b000, rd, 7'b0111011};
            4, 5, 6: return {7'b0010000, s2, s1, 3'(((k - 4) + 1) * 2), rd, 7'b0111011};
            default: return {6'b000010, sh, s1, 3'b001, rd, 7'b0011011};
        endcase
    endfunction

    // One request, one response check, one idle check.
    task automatic run_one(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b,
                           input logic [2:0] caps, input string req);
        logic [64:0] e64, e32;
        bit on = caps[0] | (caps[1] & caps[2]);
        @(negedge clk);
        req_insn = w; rs1 = a; rs2 = b;
        cap_a = caps[0]; cap_b = caps[1]; b_on = caps[2];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        e64 = model(w, a, b, on, 1'b1);
        e32 = model(w, a, b, on, 1'b0);
        check(vld64 == 1'b1, {req, " R8 valid"}, 64'(vld64), 64'd1);
        check(rd64 == w[11:7], {req, " R8 rd"}, 64'(rd64), 64'(w[11:7]));
        check(ill64 == e64[64], {req, " illegal(64)"}, 64'(ill64), 64'(e64[64]));
        check(res64 == e64[63:0], {req, " result(64) R11"}, res64, e64[63:0]);
        check(wen64 == !e64[64], {req, " R7 wr_en(64)"}, 64'(wen64), 64'(!e64[64]));
        check(ill32 == e32[64], {req, " R5 illegal(32)"}, 64'(ill32), 64'(e32[64]));
        check(res32 == e32[31:0], {req, " R5 result(32)"}, 64'(res32), 64'(e32[31:0]));
        check(wen32 == !e32[64], {req, " R7 wr_en(32)"}, 64'(wen32), 64'(!e32[64]));
        @(negedge clk);
        check(vld64 == 1'b0 && vld32 == 1'b0, {req, " R10 idle"}, 64'(vld64), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] edge_a [4];
        logic [63:0] edge_b [4];
        edge_a[0] = 64'hFFFF_FFFF_0000_0001; edge_b[0] = 64'h0;
        edge_a[1] = 64'h0000_0000_8000_0001; edge_b[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        edge_a[2] = 64'hFFFF_FFFF_FFFF_FFFF; edge_b[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        edge_a[3] = 64'h8000_0000_8000_0000; edge_b[3] = 64'h7FFF_FFFF_8000_0000;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(vld64 == 0 && vld32 == 0, "R9 valid in reset", 64'(vld64), 64'd0);
        check(wen64 == 0 && wen32 == 0, "R9 wr_en in reset", 64'(wen64), 64'd0);
        check(rdy64 == 0, "R9 ready in reset", 64'(rdy64), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rdy64 == 1 && rdy32 == 1, "R9 ready after reset", 64'(rdy64), 64'd1);
        check(vld64 == 0, "R9 valid after reset", 64'(vld64), 64'd0);

        // R1-R4 with random operands on every encoding
        for (int k = 0; k < 8; k++) begin
            for (int t = 0; t < 24; t++) begin
                run_one(enc(k, 5'($urandom), 5'($urandom), 5'($urandom), 6'($urandom)),
                        {$urandom, $urandom}, {$urandom, $urandom}, 3'b001,
                        (k < 3) ? "R1" : (k == 3) ? "R2" : (k < 7) ? "R3" : "R4");
            end
            for (int e = 0; e < 4; e++) begin
                run_one(enc(k, 5'd7, 5'd1, 5'd2, 6'd63), edge_a[e], edge_b[e], 3'b001, "R11 edge");
                run_one(enc(k, 5'd8, 5'd3, 5'd4, 6'd32), edge_a[e], edge_b[e], 3'b001, "R4 edge");
                run_one(enc(k, 5'd0, 5'd3, 5'd4, 6'd0),  edge_a[e], edge_b[e], 3'b001, "R4 zero");
            end
        end

        // R6: all capability combinations
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 8; c++) begin
                run_one(enc(k, 5'd5, 5'd6, 5'd9, 6'd17), {$urandom, $urandom},
                        {$urandom, $urandom}, 3'(c), "R6");
            end
        end

        // R7: every single-bit corruption of every encoding
        for (int k = 0; k < 8; k++) begin
            for (int bt = 0; bt < 32; bt++) begin
                run_one(enc(k, 5'd11, 5'd12, 5'd13, 6'd5) ^ (32'd1 << bt),
                        {$urandom, $urandom}, {$urandom, $urandom}, 3'b110, "R7 flip");
            end
        end

        // R7: random words
        for (int t = 0; t < 200; t++) begin
            run_one($urandom, {$urandom, $urandom}, {$urandom, $urandom}, 3'b001, "R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule